// File: doc/BRIEF.md
# USB endpoint status command controller

This block keeps the status of sixteen endpoints of a USB device controller: a control OUT endpoint (index 0), a control IN endpoint (index 1), and endpoints 1 to 14 (indices 2 to 15). A CPU sends it single-byte commands that stall, unstall or validate one endpoint. These commands have no data phase. The USB packet engine reports per-endpoint events as pulses: a set-up token seen, a set-up packet written, a packet received and a packet done. The block updates its per-endpoint state from both sources in the same clock cycle.

Each endpoint holds a stall flag, full flags for a primary and a secondary buffer, the next data PID, a set-up-present flag, a sticky set-up-overwritten flag, and a selector for the buffer the CPU may access. A parameter decides which endpoints have a second buffer. The CPU reads a status byte through a combinational read port. A strobe on that port clears the overwritten flag at the next clock edge.

Top module: `ep_status_ctrl`

## Requirements
- R1: After reset every endpoint's status byte reads 0x00.
- R2: Command 0x40+i (i = 0..15) sets bit 7 (stalled) of endpoint i only and clears its bit 2 (set-up present).
- R3: Command 0x80+i unstalls endpoint i and reinitializes it. Bits 7, 6, 5, 4, 2 and 1 become 0. Bit 3 is kept.
- R4: Command 0x60+i (i = 1..15) sets the full flag of the CPU-selected buffer. That is bit 5 (primary) when bit 1 is 0, and bit 6 (secondary) when bit 1 is 1. On a single-buffered endpoint, bit 1 stays 0 and bit 6 stays 0.
- R5: On a double-buffered endpoint, each validate command also inverts bit 1.
- R6: Every command code outside 0x40..0x4F, 0x80..0x8F and 0x61..0x6F has no effect. This includes 0x60.
- R7: usb_evt = 2 (packet done) on endpoint usb_ep clears the full flag of the USB-side buffer and inverts bit 4 (data PID, 1 = DATA1). On a double-buffered endpoint the USB side then moves to the other buffer. On endpoint 0 it also clears bit 2.
- R8: usb_evt = 1 (packet received) on endpoint usb_ep sets the full flag of the USB-side buffer. On a double-buffered endpoint the USB side then moves to the other buffer. Both buffer sides start at the primary buffer.
- R9: A setup_tok pulse unstalls endpoints 0 and 1 and sets their bit 4 to 0. An endpoint that was stalled is also reinitialized as in R3. An endpoint that was not stalled keeps its full flags and bit 2.
- R10: When a stall command and setup_tok hit the same control endpoint in one cycle, the endpoint ends unstalled and reinitialized.
- R11: usb_evt = 3 (set-up packet written) sets bits 2 and 5 of endpoint 0. If bit 2 was already 1, it also sets bit 3 (overwritten).
- R12: Bit 3 is sticky. Only a read strobe (rd_en with rd_ep = 0) clears it, at the clock edge that samples the strobe. A set in the same cycle wins over the clear.
- R13: rd_status follows rd_ep combinationally, and bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command byte |
| setup_tok | input | 1 | Set-up token seen on the control pipe |
| usb_evt | input | 2 | USB event: 0 none, 1 packet received, 2 packet done, 3 set-up packet written |
| usb_ep | input | 4 | Endpoint index for usb_evt codes 1 and 2 |
| rd_en | input | 1 | Read strobe, clears the overwritten flag of the endpoint read |
| rd_ep | input | 4 | Endpoint index for the status read |
| rd_status | output | 8 | Status byte of endpoint rd_ep |

## Verification
The bench builds the block with its defaults: sixteen endpoints, with indices 8 to 15 double-buffered and indices 0 to 7 single-buffered. This places both buffering variants side by side, so the selector toggling and the USB-side alternation can be compared against endpoints that must never touch a secondary buffer. Because the index field of the command code covers exactly the endpoint count, all 256 command codes can be swept from reset and every decoded and undecoded code checked against all sixteen status bytes. Directed sequences then cover the control-pipe corner cases: a set-up token meeting a stall in the same cycle, overwrite versus read-clear on the same edge, and flushing a stalled endpoint while the sticky flag survives.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

   // USB-side event codes carried on usb_evt
   localparam logic [1:0] EVT_NONE  = 2'd0;
   localparam logic [1:0] EVT_RX    = 2'd1;
   localparam logic [1:0] EVT_DONE  = 2'd2;
   localparam logic [1:0] EVT_SETUP = 2'd3;

   // Upper nibble of each command family
   localparam logic [3:0] NIB_STALL   = 4'h4;
   localparam logic [3:0] NIB_VALID   = 4'h6;
   localparam logic [3:0] NIB_UNSTALL = 4'h8;

   typedef struct packed {
      logic       stall;
      logic [1:0] full;     // [1] secondary, [0] primary
      logic       pid;      // next data PID, 1 = DATA1
      logic       ovw;      // set-up overwritten, sticky
      logic       setup;    // buffer holds a set-up packet
      logic       cpu_sel;  // buffer the CPU side addresses
      logic       usb_sel;  // buffer the USB side addresses
   } ep_state_t;

   // Reinitialization on any unstall: flush everything except the sticky flag
   function automatic ep_state_t ep_reinit(input ep_state_t s);
      ep_state_t r;
      r      = '0;
      r.ovw  = s.ovw;
      return r;
   endfunction

endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
   import ep_status_pkg::*;
#(
   parameter int NUM_EP = 16
) (
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   output logic [NUM_EP-1:0] stall_hit,
   output logic [NUM_EP-1:0] unstall_hit,
   output logic [NUM_EP-1:0] valid_hit
);

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         assign stall_hit[i]   = cmd_valid && (cmd_code == {NIB_STALL,   4'(i)});
         assign unstall_hit[i] = cmd_valid && (cmd_code == {NIB_UNSTALL, 4'(i)});
         if (i == 0) begin : g_no_valid
            // the control OUT endpoint is never validated by the CPU
            assign valid_hit[i] = 1'b0;
         end else begin : g_valid
            assign valid_hit[i] = cmd_valid && (cmd_code == {NIB_VALID, 4'(i)});
         end
      end
   endgenerate

endmodule

// File: rtl/ep_event_route.sv
module ep_event_route
   import ep_status_pkg::*;
#(
   parameter int NUM_EP = 16,
   localparam int IDX_W = $clog2(NUM_EP)
) (
   input  logic [1:0]        usb_evt,
   input  logic [IDX_W-1:0]  usb_ep,
   input  logic              setup_tok,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_ep,
   output logic [NUM_EP-1:0] rx_hit,
   output logic [NUM_EP-1:0] done_hit,
   output logic [NUM_EP-1:0] srx_hit,
   output logic [NUM_EP-1:0] tok_hit,
   output logic [NUM_EP-1:0] rdclr_hit
);

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         assign rx_hit[i]    = (usb_evt == EVT_RX)   && (usb_ep == IDX_W'(i));
         assign done_hit[i]  = (usb_evt == EVT_DONE) && (usb_ep == IDX_W'(i));
         assign rdclr_hit[i] = rd_en && (rd_ep == IDX_W'(i));
         if (i < 2) begin : g_ctrl
            assign tok_hit[i] = setup_tok;
         end else begin : g_data
            assign tok_hit[i] = 1'b0;
         end
         if (i == 0) begin : g_srx
            assign srx_hit[i] = (usb_evt == EVT_SETUP);
         end else begin : g_nosrx
            assign srx_hit[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/ep_state_slice.sv
module ep_state_slice
   import ep_status_pkg::*;
#(
   parameter int DOUBLE    = 0,
   parameter int CTRL      = 0,
   parameter int SETUP_CAP = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stall_cmd,
   input  logic      unstall_cmd,
   input  logic      valid_cmd,
   input  logic      setup_tok,
   input  logic      pkt_rx,
   input  logic      pkt_done,
   input  logic      setup_rx,
   input  logic      rd_clr,
   output ep_state_t state_q
);

   ep_state_t nxt;

   always_comb begin
      nxt = state_q;
      // read-clear first so that a set later in this cycle wins
      if (rd_clr) nxt.ovw = 1'b0;
      if (stall_cmd) begin
         nxt.stall = 1'b1;
         nxt.setup = 1'b0;
      end
      if (unstall_cmd) nxt = ep_reinit(nxt);
      // set-up token overrides a stall issued in the same cycle
      if ((CTRL != 0) && setup_tok) begin
         if (nxt.stall) nxt = ep_reinit(nxt);
         nxt.pid = 1'b0;
      end
      if (valid_cmd) begin
         nxt.full[nxt.cpu_sel] = 1'b1;
         if (DOUBLE != 0) nxt.cpu_sel = ~nxt.cpu_sel;
      end
      if (pkt_rx) begin
         nxt.full[nxt.usb_sel] = 1'b1;
         if (DOUBLE != 0) nxt.usb_sel = ~nxt.usb_sel;
      end
      if (pkt_done) begin
         nxt.full[nxt.usb_sel] = 1'b0;
         nxt.pid               = ~nxt.pid;
         if (DOUBLE != 0)    nxt.usb_sel = ~nxt.usb_sel;
         if (SETUP_CAP != 0) nxt.setup   = 1'b0;
      end
      if ((SETUP_CAP != 0) && setup_rx) begin
         if (nxt.setup) nxt.ovw = 1'b1;
         nxt.setup   = 1'b1;
         nxt.full[0] = 1'b1;
      end
      if (DOUBLE == 0) begin
         nxt.full[1] = 1'b0;
         nxt.cpu_sel = 1'b0;
         nxt.usb_sel = 1'b0;
      end
      if (SETUP_CAP == 0) begin
         nxt.setup = 1'b0;
         nxt.ovw   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= nxt;
   end

endmodule

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
   import ep_status_pkg::*;
#(
   parameter int          NUM_EP   = 16,
   parameter logic [15:0] DBL_MASK = 16'hFF00,
   localparam int         IDX_W    = $clog2(NUM_EP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_code,
   input  logic             setup_tok,
   input  logic [1:0]       usb_evt,
   input  logic [IDX_W-1:0] usb_ep,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_ep,
   output logic [7:0]       rd_status
);

   generate
      if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_count
         $error("ep_status_ctrl: NUM_EP must lie in 2..16");
      end
      if (DBL_MASK[1:0] != 2'b00) begin : g_bad_mask
         $error("ep_status_ctrl: control endpoints must be single-buffered");
      end
   endgenerate

   logic [NUM_EP-1:0] stall_hit, unstall_hit, valid_hit;
   logic [NUM_EP-1:0] rx_hit, done_hit, srx_hit, tok_hit, rdclr_hit;

   ep_cmd_decode #(.NUM_EP(NUM_EP)) dec_i (
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .stall_hit   (stall_hit),
      .unstall_hit (unstall_hit),
      .valid_hit   (valid_hit)
   );

   ep_event_route #(.NUM_EP(NUM_EP)) route_i (
      .usb_evt   (usb_evt),
      .usb_ep    (usb_ep),
      .setup_tok (setup_tok),
      .rd_en     (rd_en),
      .rd_ep     (rd_ep),
      .rx_hit    (rx_hit),
      .done_hit  (done_hit),
      .srx_hit   (srx_hit),
      .tok_hit   (tok_hit),
      .rdclr_hit (rdclr_hit)
   );

   ep_state_t         st [NUM_EP];
   logic [7:0]        stat_byte [NUM_EP];
   logic [NUM_EP-1:0] stall_v, fullp_v, fulls_v, ovw_v, usbsel_v;

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_slice
         ep_state_slice #(
            .DOUBLE    (DBL_MASK[i] ? 1 : 0),
            .CTRL      ((i < 2) ? 1 : 0),
            .SETUP_CAP ((i == 0) ? 1 : 0)
         ) slice_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .stall_cmd   (stall_hit[i]),
            .unstall_cmd (unstall_hit[i]),
            .valid_cmd   (valid_hit[i]),
            .setup_tok   (tok_hit[i]),
            .pkt_rx      (rx_hit[i]),
            .pkt_done    (done_hit[i]),
            .setup_rx    (srx_hit[i]),
            .rd_clr      (rdclr_hit[i]),
            .state_q     (st[i])
         );
         assign stat_byte[i] = {st[i].stall, st[i].full[1], st[i].full[0], st[i].pid,
                                st[i].ovw, st[i].setup, st[i].cpu_sel, 1'b0};
         assign stall_v[i]  = st[i].stall;
         assign fullp_v[i]  = st[i].full[0];
         assign fulls_v[i]  = st[i].full[1];
         assign ovw_v[i]    = st[i].ovw;
         assign usbsel_v[i] = st[i].usb_sel;
      end
   endgenerate

   assign rd_status = (32'(rd_ep) < NUM_EP) ? stat_byte[rd_ep] : 8'h00;

endmodule

// File: rtl/ep_status_chk.sv
module ep_status_chk #(
   parameter int NUM_EP = 16,
   localparam int IDX_W = $clog2(NUM_EP)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic              setup_tok,
   input logic [1:0]        usb_evt,
   input logic              rd_en,
   input logic [IDX_W-1:0]  rd_ep,
   input logic              rd_bit0,
   input logic [NUM_EP-1:0] stall_v,
   input logic [NUM_EP-1:0] fullp_v,
   input logic [NUM_EP-1:0] fulls_v,
   input logic [NUM_EP-1:0] ovw_v,
   input logic [NUM_EP-1:0] usbsel_v
);

   logic [15:0] stall16, fullp16, fulls16, ovw16, usbsel16;
   logic        idx_ok;

   assign stall16  = 16'(stall_v);
   assign fullp16  = 16'(fullp_v);
   assign fulls16  = 16'(fulls_v);
   assign ovw16    = 16'(ovw_v);
   assign usbsel16 = 16'(usbsel_v);
   assign idx_ok   = 32'(cmd_code[3:0]) < NUM_EP;

   p_bit0_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bit0 == 1'b0);

   p_stall_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code[7:4] == 4'h4 && idx_ok && !setup_tok)
      |=> stall16[$past(cmd_code[3:0])]);

   p_unstall_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code[7:4] == 4'h8 && idx_ok && usb_evt == 2'd0)
      |=> (!stall16[$past(cmd_code[3:0])] && !fullp16[$past(cmd_code[3:0])]
           && !fulls16[$past(cmd_code[3:0])]));

   p_validate_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code[7:4] == 4'h6 && cmd_code[3:0] != 4'h0 && idx_ok
       && usb_evt == 2'd0)
      |=> (fullp16[$past(cmd_code[3:0])] || fulls16[$past(cmd_code[3:0])]));

   p_ctrl_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fulls16[1:0] == 2'b00) && (usbsel16[1:0] == 2'b00));

   p_token_unstalls_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
      setup_tok |=> (!stall16[0] && !stall16[1]));

   p_ovw_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ovw16[0] && !(rd_en && rd_ep == '0)) |=> ovw16[0]);

   p_ovw_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_ep == '0 && usb_evt != 2'd3) |=> !ovw16[0]);

endmodule

bind ep_status_ctrl ep_status_chk #(.NUM_EP(NUM_EP)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .setup_tok (setup_tok),
   .usb_evt   (usb_evt),
   .rd_en     (rd_en),
   .rd_ep     (rd_ep),
   .rd_bit0   (rd_status[0]),
   .stall_v   (stall_v),
   .fullp_v   (fullp_v),
   .fulls_v   (fulls_v),
   .ovw_v     (ovw_v),
   .usbsel_v  (usbsel_v)
);

// File: tb/ep_status_ctrl_tb.sv
module ep_status_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'h00;
   logic       setup_tok = 1'b0;
   logic [1:0] usb_evt = 2'd0;
   logic [3:0] usb_ep = 4'd0;
   logic       rd_en = 1'b0;
   logic [3:0] rd_ep = 4'd0;
   logic [7:0] rd_status;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // 250 MHz: 4 time units per period
   always #2 clk = ~clk;

   ep_status_ctrl #(.NUM_EP(16), .DBL_MASK(16'hFF00)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .setup_tok(setup_tok), .usb_evt(usb_evt), .usb_ep(usb_ep),
      .rd_en(rd_en), .rd_ep(rd_ep), .rd_status(rd_status)
   );

   // bench model of the requirements
   bit       m_stall [16];
   bit [1:0] m_full  [16];
   bit       m_pid   [16];
   bit       m_ovw   [16];
   bit       m_setup [16];
   bit       m_cpu   [16];
   bit       m_usb   [16];

   function automatic bit is_dbl(int i);
      return i >= 8;
   endfunction

   function automatic logic [7:0] exp_byte(int i);
      return {m_stall[i], m_full[i][1], m_full[i][0], m_pid[i],
              m_ovw[i], m_setup[i], m_cpu[i], 1'b0};
   endfunction

   task automatic m_reinit(int i);
      m_stall[i] = 0; m_full[i] = 2'b00; m_pid[i] = 0;
      m_setup[i] = 0; m_cpu[i]  = 0;     m_usb[i] = 0;
   endtask

   task automatic m_clear();
      for (int i = 0; i < 16; i++) begin
         m_reinit(i);
         m_ovw[i] = 0;
      end
   endtask

   task automatic m_apply(bit cv, bit [7:0] code, bit tk, bit [1:0] ev, int ep,
                          bit re, int rep);
      for (int i = 0; i < 16; i++) begin
         if (re && rep == i) m_ovw[i] = 0;
         if (cv && code == {4'h4, 4'(i)}) begin m_stall[i] = 1; m_setup[i] = 0; end
         if (cv && code == {4'h8, 4'(i)}) m_reinit(i);
         if (tk && i < 2) begin
            if (m_stall[i]) m_reinit(i);
            m_pid[i] = 0;
         end
         if (cv && i >= 1 && code == {4'h6, 4'(i)}) begin
            m_full[i][m_cpu[i]] = 1;
            if (is_dbl(i)) m_cpu[i] = ~m_cpu[i];
         end
         if (ev == 2'd1 && ep == i) begin
            m_full[i][m_usb[i]] = 1;
            if (is_dbl(i)) m_usb[i] = ~m_usb[i];
         end
         if (ev == 2'd2 && ep == i) begin
            m_full[i][m_usb[i]] = 0;
            m_pid[i] = ~m_pid[i];
            if (is_dbl(i)) m_usb[i] = ~m_usb[i];
            if (i == 0) m_setup[i] = 0;
         end
         if (ev == 2'd3 && i == 0) begin
            if (m_setup[0]) m_ovw[0] = 1;
            m_setup[0] = 1;
            m_full[0][0] = 1;
         end
      end
   endtask

   // one clock cycle of stimulus, driven at the falling edge
   task automatic cyc(bit cv, bit [7:0] code, bit tk, bit [1:0] ev, int ep,
                      bit re, int rep);
      @(negedge clk);
      cmd_valid = cv; cmd_code = code; setup_tok = tk;
      usb_evt = ev; usb_ep = 4'(ep); rd_en = re; rd_ep = 4'(rep);
      @(posedge clk);
      #1;
      m_apply(cv, code, tk, ev, ep, re, rep);
      cmd_valid = 0; setup_tok = 0; usb_evt = 2'd0; rd_en = 0;
   endtask

   task automatic cmd(bit [7:0] code);
      cyc(1, code, 0, 2'd0, 0, 0, 0);
   endtask

   task automatic evt(bit [1:0] ev, int ep);
      cyc(0, 8'h00, 0, ev, ep, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      m_clear();
      rst_n = 1;
   endtask

   // inputs idle, so the state is stable while the port is scanned
   task automatic check_all(string req);
      for (int i = 0; i < 16; i++) begin
         rd_ep = 4'(i);
         #1;
         total++;
         if (rd_status !== exp_byte(i)) begin
            bad++;
            $display("FAIL %s ep%0d actual=%02h expected=%02h", req, i,
                     rd_status, exp_byte(i));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R1 actual=timeout expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      check_all("R1");

      // exhaustive command sweep from reset: R2, R3, R4, R5, R6
      for (int c = 0; c < 256; c++) begin
         do_reset();
         cmd(8'(c));
         if (c[7:4] == 4'h4)                     check_all("R2");
         else if (c[7:4] == 4'h8)                check_all("R3");
         else if (c[7:4] == 4'h6 && c[3:0] != 0) check_all(c[3] ? "R5" : "R4");
         else                                    check_all("R6");
      end

      // combinational read, bit 0 zero: R13
      do_reset();
      cmd(8'h63);
      check_all("R13");

      // double-buffered validate then packet done: R5, R7
      cmd(8'h69); cmd(8'h69); check_all("R5");
      cmd(8'h69);             check_all("R5");
      evt(2'd2, 9);           check_all("R7");
      evt(2'd2, 9);           check_all("R7");
      evt(2'd2, 3);           check_all("R7");

      // packet received on single and double endpoints: R8
      evt(2'd1, 4); evt(2'd1, 12); check_all("R8");
      evt(2'd1, 12);               check_all("R8");
      evt(2'd2, 12);               check_all("R7");

      // unstall flushes a busy endpoint: R3
      cmd(8'h4C); check_all("R2");
      cmd(8'h8C); check_all("R3");

      // set-up token on stalled and live control endpoints: R9
      cmd(8'h61); evt(2'd2, 1); cmd(8'h61);
      cmd(8'h40); cmd(8'h45); check_all("R2");
      cyc(0, 8'h00, 1, 2'd0, 0, 0, 0); check_all("R9");
      cmd(8'h41);
      cyc(0, 8'h00, 1, 2'd0, 0, 0, 0); check_all("R9");

      // stall command and set-up token in the same cycle: R10
      cmd(8'h61); evt(2'd2, 1);
      cyc(1, 8'h41, 1, 2'd0, 0, 0, 0); check_all("R10");

      // set-up packets and the overwritten flag: R11, R12
      evt(2'd3, 0); check_all("R11");
      evt(2'd3, 0); check_all("R11");
      cyc(0, 8'h00, 0, 2'd0, 0, 1, 1); check_all("R12");
      cmd(8'h80);                      check_all("R12");
      cyc(0, 8'h00, 0, 2'd0, 0, 1, 0); check_all("R12");
      evt(2'd3, 0); evt(2'd3, 0);
      cyc(0, 8'h00, 0, 2'd3, 0, 1, 0); check_all("R12");
      cmd(8'h40);                      check_all("R2");
      cmd(8'h80); evt(2'd3, 0);
      evt(2'd2, 0);                    check_all("R7");
      evt(2'd3, 0);                    check_all("R11");
      cyc(0, 8'h00, 1, 2'd0, 0, 0, 0); check_all("R9");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule